// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block tells an asynchronous DRAM controller when to run refresh cycles and how to bring the memory up after power-on. It never touches memory pins. It only raises requests that the controller acknowledges once it has run the matching cycle. The block runs from a system clock whose frequency is a parameter. At elaboration it works out two lengths in clock cycles: the gap between refreshes, from a refresh budget spread over a retention window, and the power-up pause.

After reset the scheduler first waits out the pause. It then asks for a fixed number of initialization cycles. Any cycle that pulses the row strobe qualifies, and each one is confirmed by an acknowledge. When the last of them is confirmed, ready goes high. From then on a refresh timer ticks once per interval, and every tick adds one refresh to a count of owed refreshes. Every accepted acknowledge removes one. The controller runs refreshes with the strobe order that uses the memory's internal row counter, so no row address is produced here. When the controller falls behind and the count reaches a threshold, an urgent flag is raised so that the controller can give refresh priority over host traffic.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high at a clock edge, the block clears all of its state. After that edge, init_req, ready, ref_req and ref_urgent are 0 and owed_count is 0.
- R2: The pause lasts PAUSE_CYC = ceil(CLK_HZ × PAUSE_US / 10^6) cycles, which is 10000 at the defaults. init_req is 0 for the first PAUSE_CYC−1 clock edges after reset is released and becomes 1 after edge number PAUSE_CYC.
- R3: While init_req is 1, each clock edge with init_ack = 1 counts one initialization cycle. ready becomes 1 and init_req becomes 0 after the edge that counts cycle number INIT_CYCLES, which is 8 at the defaults. ready then stays 1 until reset. init_req and ready are never both 1.
- R4: init_ack has no effect while init_req is 0, whether during the pause or after ready.
- R5: Once ready, the refresh interval is INT_CYC = floor(CLK_HZ × WINDOW_US / (REF_ROWS × 10^6)) cycles, which is 781 at the defaults (1024 refreshes per 16 ms). The first refresh is owed after the INT_CYC-th edge following the rise of ready, and one more after every further INT_CYC edges.
- R6: owed_count goes up by 1 on each interval tick and down by 1 on each edge with ref_ack = 1 while owed_count is not 0. ref_req is 1 exactly when ready is 1 and owed_count is not 0.
- R7: ref_ack at an edge where owed_count is 0 is ignored: the count stays 0 and does not wrap.
- R8: ref_urgent is 1 exactly when owed_count is at least URGENT_LEVEL, which is 4 at the defaults.
- R9: owed_count saturates at 2^OWED_W − 1, which is 15 at the defaults. A tick at that value leaves the count unchanged.
- R10: No refresh is requested or accumulated before ready. ref_req is 0 through the pause and the initialization phase, and owed_count is 0 when ready rises.
- R11: A reset in the middle of operation restarts the whole power-on sequence. The pause of R2 is counted again from the release.
- R12: A tick and an accepted acknowledge at the same edge leave owed_count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_ack | input | 1 | Controller has run one initialization cycle |
| ref_ack | input | 1 | Controller has run one refresh cycle |
| init_req | output | 1 | Request to run initialization cycles |
| ready | output | 1 | Power-on sequence complete |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed refreshes have reached the threshold |
| owed_count | output | OWED_W | Number of refreshes currently owed |

## Verification
A pause counter that is off by one, or that listens to init_ack, shows up as init_req rising one edge early or late relative to reset release. It is visible on the exact cycle where the bench samples. A wrong interval count changes the edge where owed_count first steps to 1, and the error grows with every later tick, so a small error is exposed within a few intervals. A fault in the owed counter, such as wrapping from zero or from the top, losing a cancelled tick, or a misplaced threshold, appears at the next edge as a wrong owed_count or ref_urgent value.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_READY = 2'd2
  } phase_e;

  // Cycles between refreshes, rounded down so the budget is never exceeded.
  function automatic longint unsigned refresh_interval_cycles(
    input longint unsigned clk_hz,
    input longint unsigned window_us,
    input longint unsigned rows
  );
    return (clk_hz * window_us) / (rows * 64'd1_000_000);
  endfunction

  // Power-up pause in cycles, rounded up so the pause is never short.
  function automatic longint unsigned pause_cycles(
    input longint unsigned clk_hz,
    input longint unsigned pause_us
  );
    return (clk_hz * pause_us + 64'd999_999) / 64'd1_000_000;
  endfunction

  // Bits needed to count 0 .. n-1, never less than one.
  function automatic int unsigned count_width(input longint unsigned n);
    if (n <= 64'd2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/dram_sched_poweron.sv
module dram_sched_poweron
  import dram_sched_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init_ack,
  output logic init_req,
  output logic ready,
  output logic pause_done,
  output logic init_take
);

  localparam int unsigned PW = count_width(PAUSE_CYC);
  localparam int unsigned IW = count_width(INIT_CYCLES);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);

  phase_e          phase;
  logic [PW-1:0]   pause_cnt;
  logic [IW-1:0]   init_cnt;
  logic            init_last;

  assign pause_done = (phase == PH_PAUSE) && (pause_cnt == PAUSE_LAST);
  assign init_take  = (phase == PH_INIT) && init_ack;
  assign init_last  = init_take && (init_cnt == INIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PAUSE;
      pause_cnt <= '0;
      init_cnt  <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pause_done) phase <= PH_INIT;
          else            pause_cnt <= pause_cnt + PW'(1);
        end
        PH_INIT: begin
          if (init_last)      phase <= PH_READY;
          else if (init_take) init_cnt <= init_cnt + IW'(1);
        end
        default: ;
      endcase
    end
  end

  assign init_req = (phase == PH_INIT);
  assign ready    = (phase == PH_READY);

endmodule

// File: rtl/dram_sched_timer.sv
module dram_sched_timer
  import dram_sched_pkg::*;
#(
  parameter int unsigned INT_CYC = 781
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int unsigned TW = count_width(INT_CYC);
  localparam logic [TW-1:0] TMR_LAST = TW'(INT_CYC - 1);

  logic [TW-1:0] tmr;

  assign tick = run && (tmr == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) tmr <= '0;
    else if (tick)   tmr <= '0;
    else             tmr <= tmr + TW'(1);
  end

endmodule

// File: rtl/dram_sched_owed.sv
module dram_sched_owed #(
  parameter int unsigned OWED_W       = 4,
  parameter int unsigned URGENT_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ack,
  output logic [OWED_W-1:0] owed,
  output logic              pending,
  output logic              urgent,
  output logic              take
);

  localparam logic [OWED_W-1:0] OWED_MAX = '1;
  localparam longint unsigned   MAX_VAL  = (64'd1 << OWED_W) - 64'd1;

  assign pending = (owed != '0);
  assign take    = ack && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (owed != OWED_MAX) owed <= owed + OWED_W'(1);
        2'b01:   owed <= owed - OWED_W'(1);
        default: ;
      endcase
    end
  end

  generate
    if (URGENT_LEVEL == 0) begin : g_urg_always
      assign urgent = 1'b1;
    end else if (longint'(URGENT_LEVEL) > MAX_VAL) begin : g_urg_never
      assign urgent = 1'b0;
    end else begin : g_urg_cmp
      localparam logic [OWED_W-1:0] URG_TH = OWED_W'(URGENT_LEVEL);
      assign urgent = (owed >= URG_TH);
    end
  endgenerate

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_sched_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned WINDOW_US    = 16000,
  parameter int unsigned REF_ROWS     = 1024,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned OWED_W       = 4,
  parameter int unsigned URGENT_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_ack,
  input  logic              ref_ack,
  output logic              init_req,
  output logic              ready,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic [OWED_W-1:0] owed_count
);

  localparam int unsigned INT_CYC   = 32'(refresh_interval_cycles(CLK_HZ, WINDOW_US, REF_ROWS));
  localparam int unsigned PAUSE_CYC = 32'(pause_cycles(CLK_HZ, PAUSE_US));

  // Internal events brought out for the checker.
  logic pause_done;
  logic init_take;
  logic tmr_tick;
  logic ack_take;
  logic owed_pending;

  dram_sched_poweron #(
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_poweron (
    .clk       (clk),
    .rst       (rst),
    .init_ack  (init_ack),
    .init_req  (init_req),
    .ready     (ready),
    .pause_done(pause_done),
    .init_take (init_take)
  );

  dram_sched_timer #(
    .INT_CYC(INT_CYC)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .run (ready),
    .tick(tmr_tick)
  );

  dram_sched_owed #(
    .OWED_W      (OWED_W),
    .URGENT_LEVEL(URGENT_LEVEL)
  ) u_owed (
    .clk    (clk),
    .rst    (rst),
    .tick   (tmr_tick),
    .ack    (ref_ack),
    .owed   (owed_count),
    .pending(owed_pending),
    .urgent (ref_urgent),
    .take   (ack_take)
  );

  assign ref_req = ready && owed_pending;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk
  import dram_sched_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned WINDOW_US = 16000,
  parameter int unsigned REF_ROWS  = 1024,
  parameter int unsigned OWED_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_ack,
  input logic              init_req,
  input logic              ready,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic [OWED_W-1:0] owed_count,
  input logic              pause_done,
  input logic              init_take,
  input logic              tmr_tick,
  input logic              ack_take
);

  localparam int unsigned GAP_LAST = 32'(refresh_interval_cycles(CLK_HZ, WINDOW_US, REF_ROWS)) - 1;
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst || !ready) gap <= 0;
    else if (tmr_tick) gap <= 0;
    else               gap <= gap + 1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!init_req && !ready && !ref_req && owed_count == '0));

  p_pause_then_init_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(init_req) |-> $past(pause_done));

  p_ready_after_init_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(init_take));

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(init_req && ready));

  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    tmr_tick |-> (gap == GAP_LAST));

  p_tick_not_late_r5: assert property (@(posedge clk) disable iff (rst)
    (ready && !tmr_tick) |-> (gap < GAP_LAST));

  p_owed_up_r6: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && !ack_take && owed_count != OWED_MAX) |=> (owed_count == $past(owed_count) + 1'b1));

  p_owed_down_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !tmr_tick) |=> (owed_count == $past(owed_count) - 1'b1));

  p_idle_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_ack && owed_count == '0 && !tmr_tick) |=> (owed_count == '0));

  p_urgent_has_req_r8: assert property (@(posedge clk) disable iff (rst)
    (ref_urgent && ready) |-> ref_req);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (owed_count == OWED_MAX && !ack_take) |=> (owed_count == OWED_MAX));

  p_masked_r10: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!ref_req && owed_count == '0));

  p_cancel_r12: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && ack_take) |=> $stable(owed_count));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .CLK_HZ   (CLK_HZ),
  .WINDOW_US(WINDOW_US),
  .REF_ROWS (REF_ROWS),
  .OWED_W   (OWED_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_ack   (ref_ack),
  .init_req  (init_req),
  .ready     (ready),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .owed_count(owed_count),
  .pause_done(pause_done),
  .init_take (init_take),
  .tmr_tick  (tmr_tick),
  .ack_take  (ack_take)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

  // 16 ms / 1024 rows = 15.625 us; at 50 cycles per us that is 781.25, kept at 781.
  localparam int IVL   = (16000 * 50) / 1024;
  // 200 us at 50 cycles per us.
  localparam int PAUSE = 200 * 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_ack = 1'b0;
  logic       ref_ack = 1'b0;
  logic       init_req, ready, ref_req, ref_urgent;
  logic [3:0] owed_count;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t0 = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched u_dut (
    .clk       (clk),
    .rst       (rst),
    .init_ack  (init_ack),
    .ref_ack   (ref_ack),
    .init_req  (init_req),
    .ready     (ready),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .owed_count(owed_count)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int phase_now();
    return (cyc - t0) % IVL;
  endfunction

  task automatic t_reset_pause();
    step(3);
    chk("R1 init_req after reset", init_req, 0);
    chk("R1 ready after reset", ready, 0);
    chk("R1 owed after reset", owed_count, 0);
    chk("R1 urgent after reset", ref_urgent, 0);
    rst = 1'b0;
    init_ack = 1'b1;            // R4: acks during the pause must be ignored
    step(100);
    init_ack = 1'b0;
    step(PAUSE - 100 - 1);
    chk("R2 init_req one edge before pause end", init_req, 0);
    chk("R4 ready unaffected by early acks", ready, 0);
    chk("R10 ref_req masked in pause", ref_req, 0);
    step(1);
    chk("R2 init_req at pause end", init_req, 1);
  endtask

  task automatic t_init();
    init_ack = 1'b1;
    step(7);
    chk("R3 ready after 7 acks", ready, 0);
    chk("R3 init_req after 7 acks", init_req, 1);
    chk("R10 ref_req masked in init", ref_req, 0);
    step(1);
    init_ack = 1'b0;
    chk("R3 ready after 8 acks", ready, 1);
    chk("R3 init_req drops", init_req, 0);
    chk("R10 nothing owed at ready", owed_count, 0);
    t0 = cyc;
  endtask

  task automatic t_first_ticks();
    init_ack = 1'b1;
    step(3);
    init_ack = 1'b0;
    chk("R4 ready kept after late acks", ready, 1);
    chk("R4 init_req stays low", init_req, 0);
    step(IVL - 1 - phase_now());
    chk("R5 nothing owed before interval", owed_count, 0);
    chk("R6 no ref_req before tick", ref_req, 0);
    step(1);
    chk("R5 first refresh owed", owed_count, 1);
    chk("R6 ref_req with owed", ref_req, 1);
    step(IVL);
    chk("R5 second refresh owed", owed_count, 2);
  endtask

  task automatic t_urgent();
    step(IVL);
    chk("R8 owed 3", owed_count, 3);
    chk("R8 not urgent at 3", ref_urgent, 0);
    step(IVL);
    chk("R8 owed 4", owed_count, 4);
    chk("R8 urgent at 4", ref_urgent, 1);
  endtask

  task automatic t_ack_cancel();
    ref_ack = 1'b1;
    step(1);
    ref_ack = 1'b0;
    chk("R6 ack decrements", owed_count, 3);
    chk("R8 urgent clears below 4", ref_urgent, 0);
    chk("R6 ref_req still high", ref_req, 1);
    step(IVL - 1 - phase_now());
    ref_ack = 1'b1;
    step(1);
    ref_ack = 1'b0;
    chk("R12 tick and ack cancel", owed_count, 3);
  endtask

  task automatic t_saturate();
    step(IVL * 13);
    chk("R9 saturates at 15", owed_count, 15);
    chk("R8 urgent when saturated", ref_urgent, 1);
    step(IVL);
    chk("R9 stays at 15 after tick", owed_count, 15);
  endtask

  task automatic t_drain();
    ref_ack = 1'b1;
    step(14);
    chk("R6 drained to 1", owed_count, 1);
    step(1);
    chk("R6 drained to 0", owed_count, 0);
    chk("R6 ref_req low when empty", ref_req, 0);
    step(3);
    ref_ack = 1'b0;
    chk("R7 idle acks ignored", owed_count, 0);
    step(IVL - phase_now());
    chk("R7 next tick gives exactly 1", owed_count, 1);
  endtask

  task automatic t_midreset();
    rst = 1'b1;
    step(2);
    chk("R11 ready cleared", ready, 0);
    chk("R11 owed cleared", owed_count, 0);
    chk("R11 ref_req cleared", ref_req, 0);
    chk("R11 urgent cleared", ref_urgent, 0);
    chk("R11 init_req cleared", init_req, 0);
    rst = 1'b0;
    step(PAUSE - 1);
    chk("R11 pause restarted", init_req, 0);
    step(1);
    chk("R11 init after restarted pause", init_req, 1);
  endtask

  initial begin
    t_reset_pause();
    t_init();
    t_first_ticks();
    t_urgent();
    t_ack_cancel();
    t_saturate();
    t_drain();
    t_midreset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule